// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers a set of event sources into a secondary interrupt unit and forwards that unit's summary into one bit of a primary unit, which drives a single CPU interrupt line. Each secondary identity bit can hold a visible pending event and one more event queued behind it. Once the visible event is cleared, the queued one reappears in the identity bit a single clock later. The primary unit captures the secondary summary only on its rising edge. If the secondary summary never returns to zero, later secondary events cannot raise the primary bit. Software recovers by writing the secondary enables to zero and then writing them back, which produces a fresh rising edge.

Software reaches both levels through a small register bus. Reads are combinational and have no side effects. Identity and overflow registers use write-one-to-clear. Each secondary source bit is run by a four-state slot machine. SLOT_EMPTY moves to SLOT_PEND on an event. SLOT_PEND moves to SLOT_PEND_Q on an event without a clear, and back to SLOT_EMPTY on a clear without an event. A clear together with an event keeps it in SLOT_PEND. SLOT_PEND_Q moves to SLOT_REFILL on a clear without an event, and stays in SLOT_PEND_Q on a clear with an event. In SLOT_PEND_Q an event without a clear is dropped and flags overflow. SLOT_REFILL shows the identity bit as zero for one cycle. From there it moves to SLOT_PEND, or to SLOT_PEND_Q if another event arrives in that cycle.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: A rising edge on `sec_src[i]` sets secondary identity bit i on the next clock, unless mask bit i (address 2, 1 = blocked) is set. A masked edge leaves the identity bit unchanged.
- R2: Secondary identity (address 0) is write-one-to-clear. A clear and a new event in the same cycle leave the bit set, and one later clear empties it with no refill.
- R3: An event that arrives while the bit is pending is queued. Clearing the bit then reads 0 for exactly one cycle, and the bit reads 1 again on the next cycle.
- R4: An event that arrives while both the pending and queued slots are full is dropped. It sets sticky overflow bit i (address 3, write-one-to-clear).
- R5: The secondary summary is the OR over (identity AND enable), with enables at address 1. Primary identity bit 0 (address 4, write-one-to-clear) is set one clock after the summary rises, and only on that rising edge.
- R6: While the summary stays high, new secondary events do not set primary bit 0 again, even after that primary bit has been cleared.
- R7: Writing 0 to the secondary enables and then writing them back, while an identity bit is still set, sets primary bit 0 again.
- R8: Primary mask bit 0 (address 6, 1 = blocked) stops summary edges from setting primary bit 0.
- R9: `cpu_irq` is a register that takes the master bit (address 5, bit 15) AND primary identity bit 0 AND the cascade enable (address 5, bit 0). With master at 0 the line is low.
- R10: Reset clears all identity, queue, enable, mask and overflow state. A source that is high during reset produces no event in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_src | input | N_SRC | Secondary event sources, captured on their rising edge |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| cpu_irq | output | 1 | Registered interrupt line to the CPU |

## Verification
The first pattern is a single event, which shows capture and the one-cycle delay into the primary bit. A masked edge is set against an unmasked one. A second event before the clear checks the one-cycle gap and the refill. A third event checks the drop and the sticky overflow flag. A second source fired while the summary is still high shows that the primary bit does not set again. The enable-off and enable-on sequence shows that the edge comes back. A clear written in the same cycle as an event separates the "set wins" rule from a refill. Toggling the master bit and the primary mask shows that each one gates the line independently of the pending state.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_SEC_ID   = 3'd0;
    localparam logic [ADDR_W-1:0] A_SEC_EN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_SEC_MASK = 3'd2;
    localparam logic [ADDR_W-1:0] A_SEC_OVF  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PRI_ID   = 3'd4;
    localparam logic [ADDR_W-1:0] A_PRI_EN   = 3'd5;
    localparam logic [ADDR_W-1:0] A_PRI_MASK = 3'd6;

    typedef enum logic [1:0] {
        SLOT_EMPTY  = 2'd0,
        SLOT_PEND   = 2'd1,
        SLOT_PEND_Q = 2'd2,
        SLOT_REFILL = 2'd3
    } slot_state_e;

endpackage

// File: rtl/sec_slot.sv
module sec_slot
    import irq_cascade_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic pend,
    output logic queued,
    output logic drop
);

    slot_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (evt) state_d = SLOT_PEND;
            end
            SLOT_PEND: begin
                if (evt && !clr)      state_d = SLOT_PEND_Q;
                else if (!evt && clr) state_d = SLOT_EMPTY;
            end
            SLOT_PEND_Q: begin
                if (clr && !evt) state_d = SLOT_REFILL;
            end
            SLOT_REFILL: begin
                state_d = evt ? SLOT_PEND_Q : SLOT_PEND;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    always_comb begin
        pend   = 1'b0;
        queued = 1'b0;
        drop   = 1'b0;
        unique case (state_q)
            SLOT_EMPTY:  ;
            SLOT_PEND:   pend = 1'b1;
            SLOT_PEND_Q: begin
                pend   = 1'b1;
                queued = 1'b1;
                drop   = evt && !clr;
            end
            SLOT_REFILL: queued = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/sec_unit.sv
module sec_unit #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic [N_SRC-1:0] wdata,
    input  logic             wr_id,
    input  logic             wr_en,
    input  logic             wr_mask,
    input  logic             wr_ovf,
    output logic [N_SRC-1:0] id,
    output logic [N_SRC-1:0] en,
    output logic [N_SRC-1:0] mask,
    output logic [N_SRC-1:0] ovf,
    output logic [N_SRC-1:0] queued,
    output logic             sum
);

    logic [N_SRC-1:0] hist_q;
    logic             primed_q;
    logic [N_SRC-1:0] evt;
    logic [N_SRC-1:0] clr;
    logic [N_SRC-1:0] drop;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q   <= '0;
            primed_q <= 1'b0;
            en       <= '0;
            mask     <= '0;
            ovf      <= '0;
        end else begin
            hist_q   <= src;
            primed_q <= 1'b1;
            if (wr_en)   en   <= wdata;
            if (wr_mask) mask <= wdata;
            ovf <= (ovf & ~(wr_ovf ? wdata : '0)) | drop;
        end
    end

    assign evt = {N_SRC{primed_q}} & src & ~hist_q & ~mask;
    assign clr = wr_id ? wdata : '0;

    for (genvar i = 0; i < N_SRC; i++) begin : g_slot
        sec_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt[i]),
            .clr    (clr[i]),
            .pend   (id[i]),
            .queued (queued[i]),
            .drop   (drop[i])
        );
    end

    assign sum = |(id & en);

endmodule

// File: rtl/pri_unit.sv
module pri_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic sum,
    input  logic wd_cascade,
    input  logic wd_master,
    input  logic wr_id,
    input  logic wr_en,
    input  logic wr_mask,
    output logic pri_id,
    output logic pri_en,
    output logic master_en,
    output logic pri_mask,
    output logic cpu_irq
);

    logic sum_q;
    logic rise;

    assign rise = sum && !sum_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q     <= 1'b0;
            pri_id    <= 1'b0;
            pri_en    <= 1'b0;
            master_en <= 1'b0;
            pri_mask  <= 1'b0;
            cpu_irq   <= 1'b0;
        end else begin
            sum_q  <= sum;
            pri_id <= (rise && !pri_mask) || (pri_id && !(wr_id && wd_cascade));
            if (wr_en) begin
                pri_en    <= wd_cascade;
                master_en <= wd_master;
            end
            if (wr_mask) pri_mask <= wd_cascade;
            cpu_irq <= master_en && pri_id && pri_en;
        end
    end

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int N_SRC      = 8,
    parameter int DATA_W     = 16,
    parameter int MASTER_BIT = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  sec_src,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_irq
);

    logic [N_SRC-1:0] sec_id, sec_en, sec_mask, sec_ovf, sec_q;
    logic             sec_sum;
    logic             pri_id, pri_en, master_en, pri_mask;
    logic             ovf_wr;
    logic             unused_wdata;

    assign ovf_wr       = bus_wr && (bus_addr == A_SEC_OVF);
    assign unused_wdata = ^bus_wdata;

    sec_unit #(.N_SRC(N_SRC)) u_sec (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (sec_src),
        .wdata   (bus_wdata[N_SRC-1:0]),
        .wr_id   (bus_wr && (bus_addr == A_SEC_ID)),
        .wr_en   (bus_wr && (bus_addr == A_SEC_EN)),
        .wr_mask (bus_wr && (bus_addr == A_SEC_MASK)),
        .wr_ovf  (ovf_wr),
        .id      (sec_id),
        .en      (sec_en),
        .mask    (sec_mask),
        .ovf     (sec_ovf),
        .queued  (sec_q),
        .sum     (sec_sum)
    );

    pri_unit u_pri (
        .clk        (clk),
        .rst_n      (rst_n),
        .sum        (sec_sum),
        .wd_cascade (bus_wdata[0]),
        .wd_master  (bus_wdata[MASTER_BIT]),
        .wr_id      (bus_wr && (bus_addr == A_PRI_ID)),
        .wr_en      (bus_wr && (bus_addr == A_PRI_EN)),
        .wr_mask    (bus_wr && (bus_addr == A_PRI_MASK)),
        .pri_id     (pri_id),
        .pri_en     (pri_en),
        .master_en  (master_en),
        .pri_mask   (pri_mask),
        .cpu_irq    (cpu_irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_SEC_ID:   bus_rdata[N_SRC-1:0] = sec_id;
            A_SEC_EN:   bus_rdata[N_SRC-1:0] = sec_en;
            A_SEC_MASK: bus_rdata[N_SRC-1:0] = sec_mask;
            A_SEC_OVF:  bus_rdata[N_SRC-1:0] = sec_ovf;
            A_PRI_ID:   bus_rdata[0] = pri_id;
            A_PRI_EN: begin
                bus_rdata[0]          = pri_en;
                bus_rdata[MASTER_BIT] = master_en;
            end
            A_PRI_MASK: bus_rdata[0] = pri_mask;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
    parameter int N_SRC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sec_sum,
    input logic [N_SRC-1:0] sec_id,
    input logic [N_SRC-1:0] sec_q,
    input logic [N_SRC-1:0] sec_ovf,
    input logic             ovf_wr,
    input logic             pri_id,
    input logic             master_en,
    input logic             cpu_irq
);

    AST_PRI_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pri_id) |-> ($past(sec_sum) && !$past(sec_sum, 2))); // R5

    AST_NO_SET_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sec_sum) && $past(sec_sum, 2)) |-> !$rose(pri_id)); // R6

    AST_REFILL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ((sec_q & ~sec_id) != '0) |=> ((sec_id & $past(sec_q & ~sec_id)) == $past(sec_q & ~sec_id))); // R3

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ovf_wr) |-> ((sec_ovf & $past(sec_ovf)) == $past(sec_ovf))); // R4

    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !cpu_irq); // R9

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> $past(pri_id)); // R9

endmodule

bind irq_cascade_ctrl irq_cascade_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_sum   (sec_sum),
    .sec_id    (sec_id),
    .sec_q     (sec_q),
    .sec_ovf   (sec_ovf),
    .ovf_wr    (ovf_wr),
    .pri_id    (pri_id),
    .master_en (master_en),
    .cpu_irq   (cpu_irq)
);

// File: tb/irq_cascade_ctrl_tb.sv
module irq_cascade_ctrl_tb;

    localparam int N_SRC  = 8;
    localparam int DATA_W = 16;
    localparam int A_IRQ  = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_SRC-1:0]  sec_src = '0;
    logic [2:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int    exp_q[$];
    int    adr_q[$];
    string tag_q[$];
    event  ev_chk;

    always #10 clk = ~clk;

    irq_cascade_ctrl #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_src   (sec_src),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(ev_chk);
            while (exp_q.size() > 0) begin
                int    a;
                int    e;
                int    act;
                string t;
                a = adr_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                act = (a == A_IRQ) ? int'(cpu_irq) : int'(bus_rdata);
                checks++;
                if (act != e) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", t, act, e);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_val(input int a, input int e, input string t);
        if (a != A_IRQ) bus_addr = a[2:0];
        #1;
        adr_q.push_back(a);
        exp_q.push_back(e);
        tag_q.push_back(t);
        -> ev_chk;
        #1;
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr  = a[2:0];
        bus_wdata = d[DATA_W-1:0];
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic pulse(input int i);
        @(negedge clk);
        sec_src[i] = 1'b1;
        @(negedge clk);
        sec_src[i] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        sec_src[7] = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        tick();
        expect_val(0, 0, "R10 no capture of source high through reset");
        expect_val(4, 0, "R10 primary identity after reset");
        tick();
        expect_val(1, 0, "R10 enables after reset");
        expect_val(A_IRQ, 0, "R10 irq after reset");
        sec_src[7] = 1'b0;

        wr(1, 'hFF);
        wr(5, 'h8001);
        pulse(0);
        expect_val(0, 'h01, "R1 edge captured");
        expect_val(4, 0, "R5 primary not yet set");
        tick();
        expect_val(4, 1, "R5 primary set one clock after summary rise");
        tick();
        expect_val(A_IRQ, 1, "R9 irq asserted");

        wr(2, 'h02);
        pulse(1);
        expect_val(0, 'h01, "R1 masked edge ignored");
        wr(2, 'h00);

        pulse(0);
        wr(0, 'h01);
        expect_val(0, 0, "R3 identity reads 0 in refill cycle");
        tick();
        expect_val(0, 'h01, "R3 queued event reappears");
        wr(0, 'h01);
        expect_val(0, 0, "R3 second clear");
        tick();
        expect_val(0, 0, "R3 no further refill");

        wr(4, 1);
        expect_val(4, 0, "R5 primary cleared");
        tick();
        tick();
        expect_val(A_IRQ, 0, "R9 irq drops after clear");
        pulse(2);
        tick();
        expect_val(4, 1, "R5 new rise sets primary");
        wr(4, 1);
        pulse(3);
        tick();
        tick();
        expect_val(4, 0, "R6 no set while summary high");
        expect_val(0, 'h0C, "R6 secondary bits still pending");
        wr(1, 'h00);
        tick();
        wr(1, 'hFF);
        tick();
        expect_val(4, 1, "R7 enable toggle regenerates edge");

        wr(5, 'h0001);
        tick();
        tick();
        expect_val(A_IRQ, 0, "R9 master off holds irq low");
        expect_val(4, 1, "R9 primary still pending with master off");
        wr(5, 'h8001);
        tick();
        expect_val(A_IRQ, 1, "R9 master on raises irq");

        wr(0, 'hFF);
        wr(4, 1);
        expect_val(0, 0, "R2 all secondary cleared");
        pulse(4);
        pulse(4);
        pulse(4);
        expect_val(3, 'h10, "R4 overflow flag on third event");
        wr(0, 'h10);
        tick();
        expect_val(0, 'h10, "R4 queued event kept");
        wr(0, 'h10);
        tick();
        expect_val(0, 0, "R4 third event dropped");
        expect_val(3, 'h10, "R4 overflow sticky");
        wr(3, 'h10);
        expect_val(3, 0, "R4 overflow write-one-to-clear");

        pulse(5);
        fork
            wr(0, 'h20);
            pulse(5);
        join
        expect_val(0, 'h20, "R2 clear with event keeps bit");
        wr(0, 'h20);
        expect_val(0, 0, "R2 single clear empties bit");
        tick();
        expect_val(0, 0, "R2 no refill after same-cycle clear");

        wr(4, 1);
        wr(6, 1);
        pulse(6);
        tick();
        tick();
        expect_val(4, 0, "R8 primary mask blocks capture");
        expect_val(A_IRQ, 0, "R8 irq low with primary masked");

        tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule